// File: doc/BRIEF.md
# Packed Integer Lane Arithmetic Unit

This unit executes one packed-integer operation per cycle on two 64-bit operands. Each operand is split into equal lanes of 8, 16 or 32 bits, and every lane is processed on its own, with no carry, borrow or overflow passing to a neighbour lane. Add and subtract run under one of three overflow policies: wrap-around, signed clamping or unsigned clamping. Four 16-bit multiplies each return one half of the 32-bit product. Equality and signed greater-than compares write a full-lane mask of ones or zeros into the result. Full-width AND, OR and XOR are also provided. No condition flags are produced.

A caller presents an opcode, a lane-size code, an overflow-policy code, both operands and a valid strobe. The result and a matching valid flag appear on the registered output one clock later. A small decoder turns the request into a bundle of strobes. The datapath builds the lane results for all three lane sizes in parallel and then selects one.

Top module: `simdIntUnit`

## Requirements
- R1: Lane size code `laneSel` is 0 for eight 8-bit lanes, 1 for four 16-bit lanes, and 2 or 3 for two 32-bit lanes. Opcode 0 (add) with policy `satMode` 0 or 3 adds each lane modulo its width, with no carry between lanes.
- R2: Opcode 1 (subtract) with policy 0 or 3 computes A minus B in each lane modulo its width.
- R3: Policy 2 (unsigned clamping) on add or subtract sets a lane to all ones when the unsigned result exceeds the lane range, and to zero when it falls below zero.
- R4: Policy 1 (signed clamping) on add or subtract sets a lane to the largest positive value on positive overflow and to the most negative value on negative overflow.
- R5: With 32-bit lanes, policies 1 and 2 fall back to wrap-around.
- R6: Opcode 2 multiplies the four 16-bit lane pairs and keeps the low 16 bits of each product, whatever `laneSel` is.
- R7: Opcode 3 keeps the high 16 bits of each signed 16x16 product. Opcode 4 keeps the high 16 bits of each unsigned product.
- R8: Opcode 5 sets each lane of the selected size to all ones when the operand lanes are equal, and to all zeros otherwise.
- R9: Opcode 6 sets each lane to all ones when the A lane is greater than the B lane as two's-complement numbers, and to all zeros otherwise.
- R10: Opcodes 7, 8 and 9 produce the 64-bit AND, OR and XOR of the operands. Opcodes 10 to 15 produce zero.
- R11: `validOut` and `result` update on the clock edge after a cycle with `validIn` high. After a cycle with `validIn` low, `validOut` is low and `result` holds its value. A synchronous `rst` clears both `validOut` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Request strobe |
| opcode | input | 4 | Operation code |
| laneSel | input | 2 | Lane size code |
| satMode | input | 2 | Overflow policy for add and subtract |
| opA | input | 64 | First packed operand |
| opB | input | 64 | Second packed operand |
| validOut | output | 1 | Result valid, one cycle after request |
| result | output | 64 | Registered packed result |

## Verification
The bench builds the unit with its default parameters: a 64-bit word and a 16-bit multiply lane. These give eight, four and two lanes, so a carry that leaks into the next lane, a clamp in the top lane, and a sign bit sitting at every lane boundary all show up in the result. The vectors place overflowing and non-overflowing lanes side by side in the same word. They also cover the extreme values 0x7F, 0x80, 0x7FFF and 0x8000, and the 32-bit fallback from clamping to wrap-around.

// File: rtl/simdPkg.sv
package simdPkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_MULLO = 4'd2,
    OP_MULHS = 4'd3,
    OP_MULHU = 4'd4,
    OP_CMPEQ = 4'd5,
    OP_CMPGT = 4'd6,
    OP_AND   = 4'd7,
    OP_OR    = 4'd8,
    OP_XOR   = 4'd9
  } opCodeE;

  // strobes from decode to datapath
  typedef struct packed {
    logic load;
    logic doAdd;
    logic doSub;
    logic doMulLo;
    logic doMulHiS;
    logic doMulHiU;
    logic doCmpEq;
    logic doCmpGt;
    logic doAnd;
    logic doOr;
    logic doXor;
    logic satSigned;
    logic satUnsigned;
    logic lane8;
    logic lane16;
    logic lane32;
  } ctrlStrobesT;

endpackage

// File: rtl/simdCtrl.sv
module simdCtrl
  import simdPkg::*;
(
  input  logic        validIn,
  input  logic [3:0]  opcode,
  input  logic [1:0]  laneSel,
  input  logic [1:0]  satMode,
  output ctrlStrobesT strobes
);

  always_comb begin
    strobes = '0;
    strobes.load = validIn;

    unique case (opcode)
      OP_ADD:   strobes.doAdd    = 1'b1;
      OP_SUB:   strobes.doSub    = 1'b1;
      OP_MULLO: strobes.doMulLo  = 1'b1;
      OP_MULHS: strobes.doMulHiS = 1'b1;
      OP_MULHU: strobes.doMulHiU = 1'b1;
      OP_CMPEQ: strobes.doCmpEq  = 1'b1;
      OP_CMPGT: strobes.doCmpGt  = 1'b1;
      OP_AND:   strobes.doAnd    = 1'b1;
      OP_OR:    strobes.doOr     = 1'b1;
      OP_XOR:   strobes.doXor    = 1'b1;
      default:  ;
    endcase

    unique case (laneSel)
      2'd0:    strobes.lane8  = 1'b1;
      2'd1:    strobes.lane16 = 1'b1;
      default: strobes.lane32 = 1'b1;
    endcase

    // clamping exists only for the two narrow lane sizes
    if (laneSel < 2'd2) begin
      strobes.satSigned   = (satMode == 2'd1);
      strobes.satUnsigned = (satMode == 2'd2);
    end
  end

endmodule

// File: rtl/simdLaneAlu.sv
module simdLaneAlu #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] laneA,
  input  logic [LANE_W-1:0] laneB,
  input  logic              doSub,
  input  logic              satS,
  input  logic              satU,
  output logic [LANE_W-1:0] arith,
  output logic              isEq,
  output logic              isGt
);

  localparam int MSB = LANE_W - 1;

  logic [LANE_W:0]   extSum;
  logic [LANE_W-1:0] wrapRes;
  logic              carryOut;
  logic              signOvf;

  always_comb begin
    extSum   = doSub ? ({1'b0, laneA} - {1'b0, laneB})
                     : ({1'b0, laneA} + {1'b0, laneB});
    wrapRes  = extSum[LANE_W-1:0];
    carryOut = extSum[LANE_W];
    if (doSub)
      signOvf = (laneA[MSB] != laneB[MSB]) && (wrapRes[MSB] != laneA[MSB]);
    else
      signOvf = (laneA[MSB] == laneB[MSB]) && (wrapRes[MSB] != laneA[MSB]);

    if (satU && carryOut)
      arith = doSub ? '0 : '1;
    else if (satS && signOvf)
      arith = laneA[MSB] ? {1'b1, {MSB{1'b0}}} : {1'b0, {MSB{1'b1}}};
    else
      arith = wrapRes;
  end

  assign isEq = (laneA == laneB);
  assign isGt = ($signed(laneA) > $signed(laneB));

endmodule

// File: rtl/simdDatapath.sv
module simdDatapath
  import simdPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MUL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobesT       strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              validOut,
  output logic [DATA_W-1:0] result
);

  localparam int N8   = DATA_W / 8;
  localparam int N16  = DATA_W / 16;
  localparam int N32  = DATA_W / 32;
  localparam int NMUL = DATA_W / MUL_W;

  logic [DATA_W-1:0] sum8, sum16, sum32;
  logic [DATA_W-1:0] cmp8, cmp16, cmp32;
  logic [DATA_W-1:0] mulLo, mulHiS, mulHiU;
  logic [DATA_W-1:0] arithSel, cmpSel, nextRes;
  logic              useSub;

  assign useSub = strobes.doSub;

  for (genvar g = 0; g < N8; g++) begin : gLane8
    logic eq, gt;
    simdLaneAlu #(.LANE_W(8)) uAlu (
      .laneA(opA[g*8 +: 8]), .laneB(opB[g*8 +: 8]),
      .doSub(useSub), .satS(strobes.satSigned), .satU(strobes.satUnsigned),
      .arith(sum8[g*8 +: 8]), .isEq(eq), .isGt(gt)
    );
    assign cmp8[g*8 +: 8] = {8{strobes.doCmpEq ? eq : gt}};
  end

  for (genvar g = 0; g < N16; g++) begin : gLane16
    logic eq, gt;
    simdLaneAlu #(.LANE_W(16)) uAlu (
      .laneA(opA[g*16 +: 16]), .laneB(opB[g*16 +: 16]),
      .doSub(useSub), .satS(strobes.satSigned), .satU(strobes.satUnsigned),
      .arith(sum16[g*16 +: 16]), .isEq(eq), .isGt(gt)
    );
    assign cmp16[g*16 +: 16] = {16{strobes.doCmpEq ? eq : gt}};
  end

  for (genvar g = 0; g < N32; g++) begin : gLane32
    logic eq, gt;
    simdLaneAlu #(.LANE_W(32)) uAlu (
      .laneA(opA[g*32 +: 32]), .laneB(opB[g*32 +: 32]),
      .doSub(useSub), .satS(1'b0), .satU(1'b0),
      .arith(sum32[g*32 +: 32]), .isEq(eq), .isGt(gt)
    );
    assign cmp32[g*32 +: 32] = {32{strobes.doCmpEq ? eq : gt}};
  end

  // one unsigned multiplier per lane; signed high half by correction
  for (genvar g = 0; g < NMUL; g++) begin : gMul
    logic [MUL_W-1:0]   ma, mb, corr;
    logic [2*MUL_W-1:0] prodU;
    assign ma     = opA[g*MUL_W +: MUL_W];
    assign mb     = opB[g*MUL_W +: MUL_W];
    assign prodU  = ma * mb;
    assign corr   = ({MUL_W{ma[MUL_W-1]}} & mb) + ({MUL_W{mb[MUL_W-1]}} & ma);
    assign mulLo[g*MUL_W +: MUL_W]  = prodU[MUL_W-1:0];
    assign mulHiU[g*MUL_W +: MUL_W] = prodU[2*MUL_W-1:MUL_W];
    assign mulHiS[g*MUL_W +: MUL_W] = prodU[2*MUL_W-1:MUL_W] - corr;
  end

  always_comb begin
    if (strobes.lane8) begin
      arithSel = sum8;
      cmpSel   = cmp8;
    end else if (strobes.lane16) begin
      arithSel = sum16;
      cmpSel   = cmp16;
    end else begin
      arithSel = sum32;
      cmpSel   = cmp32;
    end

    nextRes = '0;
    if (strobes.doAdd || strobes.doSub)         nextRes = arithSel;
    else if (strobes.doMulLo)                   nextRes = mulLo;
    else if (strobes.doMulHiS)                  nextRes = mulHiS;
    else if (strobes.doMulHiU)                  nextRes = mulHiU;
    else if (strobes.doCmpEq || strobes.doCmpGt) nextRes = cmpSel;
    else if (strobes.doAnd)                     nextRes = opA & opB;
    else if (strobes.doOr)                      nextRes = opA | opB;
    else if (strobes.doXor)                     nextRes = opA ^ opB;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validOut <= 1'b0;
      result   <= '0;
    end else begin
      validOut <= strobes.load;
      if (strobes.load) result <= nextRes;
    end
  end

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> validOut);

  // R11
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> (!validOut && $stable(result)));

  // R10
  op_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.doAdd, strobes.doSub, strobes.doMulLo, strobes.doMulHiS,
              strobes.doMulHiU, strobes.doCmpEq, strobes.doCmpGt,
              strobes.doAnd, strobes.doOr, strobes.doXor}));

  // R1
  lane_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot({strobes.lane8, strobes.lane16, strobes.lane32}));

  // R5
  no_sat32_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.lane32 |-> !(strobes.satSigned || strobes.satUnsigned));

  // R3
  usat_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && strobes.doAdd && strobes.satUnsigned && strobes.lane8)
      |=> (result[7:0] >= $past(opA[7:0])));

  // R4
  ssat_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && strobes.doAdd && strobes.satSigned && strobes.lane16 &&
     !opA[15] && !opB[15]) |=> !result[15]);

  // R8
  eq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && strobes.doCmpEq && strobes.lane16)
      |=> (result[15:0] == '0 || result[15:0] == '1));

  // R10
  xor_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && strobes.doXor) |=> ((result ^ $past(opB)) == $past(opA)));

endmodule

// File: rtl/simdIntUnit.sv
module simdIntUnit
  import simdPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MUL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              validIn,
  input  logic [3:0]        opcode,
  input  logic [1:0]        laneSel,
  input  logic [1:0]        satMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              validOut,
  output logic [DATA_W-1:0] result
);

  ctrlStrobesT strobes;

  simdCtrl uCtrl (
    .validIn(validIn), .opcode(opcode), .laneSel(laneSel),
    .satMode(satMode), .strobes(strobes)
  );

  simdDatapath #(.DATA_W(DATA_W), .MUL_W(MUL_W)) uData (
    .clk(clk), .rst(rst), .strobes(strobes), .opA(opA), .opB(opB),
    .validOut(validOut), .result(result)
  );

endmodule

// File: tb/test_simdIntUnit.sv
module test_simdIntUnit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        validIn = 1'b0;
  logic [3:0]  opcode = '0;
  logic [1:0]  laneSel = '0;
  logic [1:0]  satMode = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        validOut;
  logic [63:0] result;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  simdIntUnit i_simdIntUnit (
    .clk(clk), .rst(rst), .validIn(validIn), .opcode(opcode),
    .laneSel(laneSel), .satMode(satMode), .opA(opA), .opB(opB),
    .validOut(validOut), .result(result)
  );

  // fields: req[4] op[4] lane[2] mode[2] a[64] b[64] exp[64]
  localparam int NVEC = 21;
  localparam logic [203:0] VECS [NVEC] = '{
    {4'd1,  4'd0, 2'd0, 2'd0, 64'h01FF_7F80_0102_0304, 64'h0101_0180_FF01_0101, 64'h0200_8000_0003_0405}, // R1
    {4'd1,  4'd0, 2'd1, 2'd3, 64'hFFFF_0001_7FFF_1234, 64'h0001_0001_0001_1111, 64'h0000_0002_8000_2345}, // R1
    {4'd1,  4'd0, 2'd2, 2'd0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0000}, // R1
    {4'd2,  4'd1, 2'd0, 2'd0, 64'h0010_0000_0000_0005, 64'h0101_0000_0000_0003, 64'hFF0F_0000_0000_0002}, // R2
    {4'd3,  4'd0, 2'd0, 2'd2, 64'hF010_FF00_807F_01FE, 64'h2010_0100_8001_0101, 64'hFF20_FF00_FF80_02FF}, // R3
    {4'd3,  4'd1, 2'd1, 2'd2, 64'h0005_0100_FFFF_0000, 64'h0006_0001_0001_0001, 64'h0000_00FF_FFFE_0000}, // R3
    {4'd4,  4'd0, 2'd0, 2'd1, 64'h7F80_40C0_01FF_7F80, 64'h01FF_40C0_FFFF_807F, 64'h7F80_7F80_00FE_FFFF}, // R4
    {4'd4,  4'd1, 2'd1, 2'd1, 64'h8000_7FFF_0000_0005, 64'h0001_FFFF_8000_0007, 64'h8000_7FFF_7FFF_FFFE}, // R4
    {4'd5,  4'd0, 2'd2, 2'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 64'h8000_0000_0000_0000}, // R5
    {4'd5,  4'd1, 2'd2, 2'd2, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0002, 64'hFFFF_FFFF_FFFF_FFFE}, // R5
    {4'd6,  4'd2, 2'd0, 2'd0, 64'h0003_FFFF_0100_1234, 64'h0005_0002_0100_0010, 64'h000F_FFFE_0000_2340}, // R6
    {4'd7,  4'd3, 2'd1, 2'd0, 64'h0003_FFFF_0100_1234, 64'h0005_0002_0100_0010, 64'h0000_FFFF_0001_0001}, // R7
    {4'd7,  4'd4, 2'd1, 2'd0, 64'h0003_FFFF_0100_1234, 64'h0005_0002_0100_0010, 64'h0000_0001_0001_0001}, // R7
    {4'd8,  4'd5, 2'd0, 2'd0, 64'h0102_0304_0506_0708, 64'h0100_0304_0006_0008, 64'hFF00_FFFF_00FF_00FF}, // R8
    {4'd8,  4'd5, 2'd3, 2'd0, 64'h1234_5678_0000_0001, 64'h1234_5678_0000_0002, 64'hFFFF_FFFF_0000_0000}, // R8
    {4'd9,  4'd6, 2'd1, 2'd0, 64'h0001_FFFF_8000_7FFF, 64'h0000_0001_7FFF_7FFF, 64'hFFFF_0000_0000_0000}, // R9
    {4'd9,  4'd6, 2'd0, 2'd0, 64'h807F_0001_FF00_0505, 64'h7F80_0000_FEFF_0605, 64'h00FF_00FF_FFFF_0000}, // R9
    {4'd10, 4'd7, 2'd0, 2'd0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_1234, 64'h00F0_1234_00FF_0000}, // R10
    {4'd10, 4'd8, 2'd0, 2'd0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_1234, 64'hFFF0_FFFF_FFFF_1234}, // R10
    {4'd10, 4'd9, 2'd0, 2'd0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_1234, 64'hFF00_EDCB_FF00_1234}, // R10
    {4'd10, 4'd12, 2'd0, 2'd0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_1234, 64'h0000_0000_0000_0000}  // R10
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check(validOut == 1'b0, "R11 reset valid", {63'd0, validOut}, 64'd0);
    check(result == '0, "R11 reset result", result, 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [203:0] v;
      v = VECS[i];
      opcode  = v[199:196];
      laneSel = v[195:194];
      satMode = v[193:192];
      opA     = v[191:128];
      opB     = v[127:64];
      validIn = 1'b1;
      @(negedge clk);
      validIn = 1'b0;
      check(validOut == 1'b1, $sformatf("R11 valid vec %0d", i), {63'd0, validOut}, 64'd1);
      check(result == v[63:0], $sformatf("R%0d vec %0d", v[203:200], i), result, v[63:0]);
    end

    // R11 hold: idle cycle with new operands leaves result unchanged
    held    = result;
    opcode  = 4'd7;
    opA     = 64'h1111_2222_3333_4444;
    opB     = '1;
    @(negedge clk);
    check(validOut == 1'b0, "R11 idle valid", {63'd0, validOut}, 64'd0);
    check(result == held, "R11 idle hold", result, held);

    // R11 one-cycle latency: output unchanged before the edge
    validIn = 1'b1;
    opcode  = 4'd9;
    @(posedge clk);
    #1;
    check(result == (64'h1111_2222_3333_4444 ^ 64'hFFFF_FFFF_FFFF_FFFF), "R11 latency",
          result, 64'hEEEE_DDDD_CCCC_BBBB);
    @(negedge clk);

    // R11 synchronous reset clears outputs even with a request present
    rst = 1'b1;
    @(negedge clk);
    check(validOut == 1'b0, "R11 reset valid mid-run", {63'd0, validOut}, 64'd0);
    check(result == '0, "R11 reset result mid-run", result, 64'd0);
    rst = 1'b0;
    validIn = 1'b0;

    // R3 unsigned subtract clamp in 8-bit lanes, next to an exact lane
    validIn = 1'b1; opcode = 4'd1; laneSel = 2'd0; satMode = 2'd2;
    opA = 64'h0000_0000_0000_0A05; opB = 64'h0000_0000_0000_0A06;
    @(negedge clk);
    validIn = 1'b0;
    check(result == 64'h0, "R3 usat sub to zero", result, 64'h0);

    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule